// File: doc/BRIEF.md
# Spare Byte Section Repacker

This block moves the out-of-band bytes of one flash page between two memory layouts. The first is a linear page buffer in which the out-of-band bytes follow the page data as one unbroken run. The second is a controller spare RAM in which every 512-byte sector of the page has its own spare slot, and the slots sit a fixed stride apart. A direction input picks the copy. Gather reads the spare RAM and writes the linear buffer. Scatter reads the linear buffer and writes the spare RAM.

A host sets the page size, the spare size and the slot stride, then raises start for one cycle. The block samples the configuration and works out the section geometry in a setup cycle. It then streams one byte per cycle. Each read goes out to the source memory, which has one cycle of read latency, and the returned byte is written to the destination in the next cycle. A one-cycle done pulse marks the end of the copy. The spare bytes are divided into one section per sector. Each section has the same even length, except the last, which takes all the bytes that are left over. The slot stride need not match the section length.

Top module: `spare_repacker`

## Requirements
- R1: The section count n is page_size divided by 512, rounded down. A result of 0 is treated as 1, and a result above MAX_SECT (default 8) is treated as MAX_SECT.
- R2: The section length L is spare_size divided by n, rounded down, with bit 0 then forced to 0. When L is 0, all spare bytes form one section at index n-1.
- R3: Byte j of section i sits at linear address page_size + i*L + j and at spare RAM address i*slot_stride + j.
- R4: Each section other than the last copies exactly L bytes. The last section copies spare_size - (n-1)*L bytes. Sections are copied in ascending order, and bytes within a section in ascending order, each byte once.
- R5: dir=0 (gather) reads only the spare RAM and writes only the linear buffer. dir=1 (scatter) reads only the linear buffer and writes only the spare RAM.
- R6: Counting the accepted start as cycle 0, the block idles in cycle 1 and issues one read per cycle from cycle 2 on. It writes the byte returned by each read in the following cycle, to the matching destination address.
- R7: done is high for exactly one cycle, in the cycle after the last write.
- R8: busy is high from the cycle after an accepted start up to, but not including, the done cycle. A start that arrives while busy is high is ignored.
- R9: dir, page_size, spare_size and slot_stride are sampled when a start is accepted. Changes to them during a copy have no effect on that copy.
- R10: With spare_size 0 there are no memory accesses, and done pulses in cycle 2.
- R11: After reset, busy, done and all four memory enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Copy request, accepted only when idle |
| dir | input | 1 | 0 gather (spare RAM to linear), 1 scatter (linear to spare RAM) |
| page_size | input | PAGE_W | Page data size in bytes |
| spare_size | input | SPARE_W | Total out-of-band byte count |
| slot_stride | input | STRIDE_W | Distance between spare RAM slots in bytes |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| lin_rd_en | output | 1 | Linear buffer read enable |
| lin_rd_addr | output | LIN_AW | Linear buffer read address |
| lin_rd_data | input | 8 | Linear buffer read data, one cycle after the enable |
| lin_wr_en | output | 1 | Linear buffer write enable |
| lin_wr_addr | output | LIN_AW | Linear buffer write address |
| lin_wr_data | output | 8 | Linear buffer write data |
| spr_rd_en | output | 1 | Spare RAM read enable |
| spr_rd_addr | output | SPR_AW | Spare RAM read address |
| spr_rd_data | input | 8 | Spare RAM read data, one cycle after the enable |
| spr_wr_en | output | 1 | Spare RAM write enable |
| spr_wr_addr | output | SPR_AW | Spare RAM write address |
| spr_wr_data | output | 8 | Spare RAM write data |

## Verification
The assertions check, on every cycle, the rules that hold locally. At most one memory is written and at most one is read at a time. Each read is followed by a write in the next cycle, and a gather write follows a spare RAM read. done never lasts two cycles. While streaming, the offset stays inside the current section and the section index stays below the count. Only the bench's scenarios can show that the address sequence, the uneven last section, the clamped section counts, the zero-length-section case and the ignored start with changed configuration give exactly the right bytes at the right addresses. The bench compares these against a behavioural model on every cycle.

// File: rtl/spr_rpk_pkg.sv
package spr_rpk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_RUN   = 2'd2,
      ST_DRAIN = 2'd3
   } rpk_state_e;

   typedef enum logic {
      DIR_GATHER  = 1'b0,
      DIR_SCATTER = 1'b1
   } rpk_dir_e;

endpackage

// File: rtl/spr_rpk_geom.sv
module spr_rpk_geom #(
   parameter int PAGE_W     = 13,
   parameter int SPARE_W    = 8,
   parameter int STRIDE_W   = 7,
   parameter int SECT_SHIFT = 9,
   parameter int MAX_SECT   = 8,
   localparam int CNT_W     = $clog2(MAX_SECT + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic                dir_i,
   input  logic [PAGE_W-1:0]   page_i,
   input  logic [SPARE_W-1:0]  spare_i,
   input  logic [STRIDE_W-1:0] stride_i,
   output logic                dir_o,
   output logic [PAGE_W-1:0]   page_o,
   output logic [SPARE_W-1:0]  spare_o,
   output logic [STRIDE_W-1:0] stride_o,
   output logic [CNT_W-1:0]    nsec_o,
   output logic [SPARE_W-1:0]  len_o,
   output logic [SPARE_W-1:0]  last_o
);

   localparam int NRAW_W = PAGE_W - SECT_SHIFT;

   logic [NRAW_W-1:0]  n_raw;
   int                 n_int;
   int                 len_int;
   logic [CNT_W-1:0]   n_c;
   logic [SPARE_W-1:0] len_c;
   logic [SPARE_W-1:0] last_c;

   assign n_raw = page_i[PAGE_W-1:SECT_SHIFT];

   generate
      if (MAX_SECT == 1) begin : g_single
         assign n_int = 1;
      end else begin : g_multi
         always_comb begin
            if (n_raw == '0)
               n_int = 1;
            else if (int'(n_raw) > MAX_SECT)
               n_int = MAX_SECT;
            else
               n_int = int'(n_raw);
         end
      end
   endgenerate

   always_comb begin
      len_int = (int'(spare_i) / n_int) & ~1;
      n_c     = CNT_W'(n_int);
      len_c   = SPARE_W'(len_int);
      last_c  = spare_i - SPARE_W'((n_int - 1) * len_int);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_o    <= 1'b0;
         page_o   <= '0;
         spare_o  <= '0;
         stride_o <= '0;
         nsec_o   <= CNT_W'(1);
         len_o    <= '0;
         last_o   <= '0;
      end else if (load_i) begin
         dir_o    <= dir_i;
         page_o   <= page_i;
         spare_o  <= spare_i;
         stride_o <= stride_i;
         nsec_o   <= n_c;
         len_o    <= len_c;
         last_o   <= last_c;
      end
   end

   // R2: latched section length is always even
   p_len_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !len_o[0]);

   // R1: latched section count within bounds
   p_nsec_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (nsec_o != '0) && (int'(nsec_o) <= MAX_SECT));

endmodule

// File: rtl/spr_rpk_seq.sv
module spr_rpk_seq
   import spr_rpk_pkg::*;
#(
   parameter int LIN_AW   = 14,
   parameter int SPR_AW   = 11,
   parameter int PAGE_W   = 13,
   parameter int SPARE_W  = 8,
   parameter int STRIDE_W = 7,
   parameter int CNT_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [PAGE_W-1:0]   page_i,
   input  logic [SPARE_W-1:0]  spare_i,
   input  logic [STRIDE_W-1:0] stride_i,
   input  logic [CNT_W-1:0]    nsec_i,
   input  logic [SPARE_W-1:0]  len_i,
   input  logic [SPARE_W-1:0]  last_i,
   output logic                load_o,
   output logic                busy_o,
   output logic                issue_o,
   output logic                last_o,
   output logic                empty_o,
   output logic [LIN_AW-1:0]   lin_addr_o,
   output logic [SPR_AW-1:0]   spr_addr_o
);

   rpk_state_e         state;
   logic [CNT_W-1:0]   sec;
   logic [SPARE_W-1:0] off;
   logic [SPARE_W-1:0] left;
   logic [LIN_AW-1:0]  lin_base;
   logic [SPR_AW-1:0]  spr_base;

   logic               last_sec;
   logic [SPARE_W-1:0] cur_len;
   logic [CNT_W-1:0]   first_sec;
   logic               sec_end;

   always_comb begin
      last_sec   = (sec == nsec_i - CNT_W'(1));
      cur_len    = last_sec ? last_i : len_i;
      first_sec  = (len_i == '0) ? (nsec_i - CNT_W'(1)) : '0;
      sec_end    = ((off + SPARE_W'(1)) == cur_len);
      load_o     = start_i && (state == ST_IDLE);
      busy_o     = (state != ST_IDLE);
      issue_o    = (state == ST_RUN);
      last_o     = issue_o && (left == SPARE_W'(1));
      empty_o    = (state == ST_SETUP) && (spare_i == '0);
      lin_addr_o = lin_base + LIN_AW'(off);
      spr_addr_o = spr_base + SPR_AW'(off);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sec      <= '0;
         off      <= '0;
         left     <= '0;
         lin_base <= '0;
         spr_base <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_i) state <= ST_SETUP;
            end
            ST_SETUP: begin
               sec      <= first_sec;
               off      <= '0;
               left     <= spare_i;
               lin_base <= LIN_AW'(page_i);
               spr_base <= SPR_AW'(first_sec) * SPR_AW'(stride_i);
               state    <= (spare_i == '0) ? ST_IDLE : ST_RUN;
            end
            ST_RUN: begin
               left <= left - SPARE_W'(1);
               if (left == SPARE_W'(1)) begin
                  state <= ST_DRAIN;
               end else if (sec_end) begin
                  sec      <= sec + CNT_W'(1);
                  off      <= '0;
                  lin_base <= lin_base + LIN_AW'(len_i);
                  spr_base <= spr_base + SPR_AW'(stride_i);
               end else begin
                  off <= off + SPARE_W'(1);
               end
            end
            ST_DRAIN: begin
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R4: offset never leaves the current section while streaming
   p_off_in_sec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> (off < cur_len));

   // R1: section index stays below the section count
   p_sec_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> (sec < nsec_i));

   // R8: a start seen while busy does not restart setup
   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && left != SPARE_W'(1)) |=> (state == ST_RUN));

endmodule

// File: rtl/spr_rpk_port.sv
module spr_rpk_port
   import spr_rpk_pkg::*;
#(
   parameter int LIN_AW = 14,
   parameter int SPR_AW = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_i,
   input  logic              issue_i,
   input  logic              last_i,
   input  logic              empty_i,
   input  logic [LIN_AW-1:0] lin_addr_i,
   input  logic [SPR_AW-1:0] spr_addr_i,
   input  logic [7:0]        lin_rd_data_i,
   input  logic [7:0]        spr_rd_data_i,
   output logic              lin_rd_en_o,
   output logic [LIN_AW-1:0] lin_rd_addr_o,
   output logic              lin_wr_en_o,
   output logic [LIN_AW-1:0] lin_wr_addr_o,
   output logic [7:0]        lin_wr_data_o,
   output logic              spr_rd_en_o,
   output logic [SPR_AW-1:0] spr_rd_addr_o,
   output logic              spr_wr_en_o,
   output logic [SPR_AW-1:0] spr_wr_addr_o,
   output logic [7:0]        spr_wr_data_o,
   output logic              done_o
);

   logic              wr_v;
   logic              wr_last;
   logic [LIN_AW-1:0] wr_lin_q;
   logic [SPR_AW-1:0] wr_spr_q;
   logic              is_gather;

   assign is_gather = (rpk_dir_e'(dir_i) == DIR_GATHER);

   always_comb begin
      lin_rd_en_o   = issue_i && !is_gather;
      spr_rd_en_o   = issue_i && is_gather;
      lin_rd_addr_o = lin_addr_i;
      spr_rd_addr_o = spr_addr_i;
      lin_wr_en_o   = wr_v && is_gather;
      spr_wr_en_o   = wr_v && !is_gather;
      lin_wr_addr_o = wr_lin_q;
      spr_wr_addr_o = wr_spr_q;
      lin_wr_data_o = spr_rd_data_i;
      spr_wr_data_o = lin_rd_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_v     <= 1'b0;
         wr_last  <= 1'b0;
         wr_lin_q <= '0;
         wr_spr_q <= '0;
         done_o   <= 1'b0;
      end else begin
         wr_v    <= issue_i;
         wr_last <= last_i;
         if (issue_i) begin
            wr_lin_q <= lin_addr_i;
            wr_spr_q <= spr_addr_i;
         end
         done_o <= (wr_v && wr_last) || empty_i;
      end
   end

   // R7: completion is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6: every read is followed by a write one cycle later
   p_wr_follows_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lin_rd_en_o || spr_rd_en_o) |=> (lin_wr_en_o || spr_wr_en_o));

   // R5: a linear write is fed by a spare RAM read
   p_gather_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lin_wr_en_o |-> $past(spr_rd_en_o));

   // R5: a spare RAM write is fed by a linear read
   p_scatter_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      spr_wr_en_o |-> $past(lin_rd_en_o));

   // R5: one memory written and one read at a time
   p_one_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lin_wr_en_o, spr_wr_en_o}) && $onehot0({lin_rd_en_o, spr_rd_en_o}));

endmodule

// File: rtl/spare_repacker.sv
module spare_repacker #(
   parameter int PAGE_W     = 13,
   parameter int SPARE_W    = 8,
   parameter int STRIDE_W   = 7,
   parameter int SECT_SHIFT = 9,
   parameter int MAX_SECT   = 8,
   parameter int LIN_AW     = 14,
   parameter int SPR_AW     = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                dir,
   input  logic [PAGE_W-1:0]   page_size,
   input  logic [SPARE_W-1:0]  spare_size,
   input  logic [STRIDE_W-1:0] slot_stride,
   output logic                busy,
   output logic                done,
   output logic                lin_rd_en,
   output logic [LIN_AW-1:0]   lin_rd_addr,
   input  logic [7:0]          lin_rd_data,
   output logic                lin_wr_en,
   output logic [LIN_AW-1:0]   lin_wr_addr,
   output logic [7:0]          lin_wr_data,
   output logic                spr_rd_en,
   output logic [SPR_AW-1:0]   spr_rd_addr,
   input  logic [7:0]          spr_rd_data,
   output logic                spr_wr_en,
   output logic [SPR_AW-1:0]   spr_wr_addr,
   output logic [7:0]          spr_wr_data
);

   localparam int CNT_W   = $clog2(MAX_SECT + 1);
   localparam int SPR_MAX = (MAX_SECT - 1) * ((1 << STRIDE_W) - 1) + (1 << SPARE_W) - 1;
   localparam int LIN_MAX = (1 << PAGE_W) - 1 + (1 << SPARE_W) - 1;

   generate
      if (MAX_SECT < 1) begin : g_bad_sect
         $error("MAX_SECT must be at least 1");
      end
      if (PAGE_W <= SECT_SHIFT) begin : g_bad_page
         $error("PAGE_W must exceed SECT_SHIFT");
      end
      if (SPR_MAX >= (1 << SPR_AW)) begin : g_bad_spr
         $error("SPR_AW too narrow for slot layout");
      end
      if (LIN_MAX >= (1 << LIN_AW)) begin : g_bad_lin
         $error("LIN_AW too narrow for page plus spare");
      end
   endgenerate

   logic                load;
   logic                dir_q;
   logic [PAGE_W-1:0]   page_q;
   logic [SPARE_W-1:0]  spare_q;
   logic [STRIDE_W-1:0] stride_q;
   logic [CNT_W-1:0]    nsec_q;
   logic [SPARE_W-1:0]  len_q;
   logic [SPARE_W-1:0]  last_q;
   logic                issue;
   logic                last_b;
   logic                empty;
   logic [LIN_AW-1:0]   lin_addr;
   logic [SPR_AW-1:0]   spr_addr;

   spr_rpk_geom #(
      .PAGE_W(PAGE_W), .SPARE_W(SPARE_W), .STRIDE_W(STRIDE_W),
      .SECT_SHIFT(SECT_SHIFT), .MAX_SECT(MAX_SECT)
   ) geom_i (
      .clk(clk), .rst_n(rst_n), .load_i(load), .dir_i(dir),
      .page_i(page_size), .spare_i(spare_size), .stride_i(slot_stride),
      .dir_o(dir_q), .page_o(page_q), .spare_o(spare_q), .stride_o(stride_q),
      .nsec_o(nsec_q), .len_o(len_q), .last_o(last_q)
   );

   spr_rpk_seq #(
      .LIN_AW(LIN_AW), .SPR_AW(SPR_AW), .PAGE_W(PAGE_W),
      .SPARE_W(SPARE_W), .STRIDE_W(STRIDE_W), .CNT_W(CNT_W)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .page_i(page_q), .spare_i(spare_q), .stride_i(stride_q),
      .nsec_i(nsec_q), .len_i(len_q), .last_i(last_q),
      .load_o(load), .busy_o(busy), .issue_o(issue), .last_o(last_b),
      .empty_o(empty), .lin_addr_o(lin_addr), .spr_addr_o(spr_addr)
   );

   spr_rpk_port #(
      .LIN_AW(LIN_AW), .SPR_AW(SPR_AW)
   ) port_i (
      .clk(clk), .rst_n(rst_n), .dir_i(dir_q), .issue_i(issue),
      .last_i(last_b), .empty_i(empty),
      .lin_addr_i(lin_addr), .spr_addr_i(spr_addr),
      .lin_rd_data_i(lin_rd_data), .spr_rd_data_i(spr_rd_data),
      .lin_rd_en_o(lin_rd_en), .lin_rd_addr_o(lin_rd_addr),
      .lin_wr_en_o(lin_wr_en), .lin_wr_addr_o(lin_wr_addr),
      .lin_wr_data_o(lin_wr_data),
      .spr_rd_en_o(spr_rd_en), .spr_rd_addr_o(spr_rd_addr),
      .spr_wr_en_o(spr_wr_en), .spr_wr_addr_o(spr_wr_addr),
      .spr_wr_data_o(spr_wr_data),
      .done_o(done)
   );

   // R8: busy and done never overlap
   p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

endmodule

// File: tb/spare_repacker_tb_top.sv
module spare_repacker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        dir = 1'b0;
   logic [12:0] page_size = '0;
   logic [7:0]  spare_size = '0;
   logic [6:0]  slot_stride = '0;
   logic        busy, done;
   logic        lin_rd_en, lin_wr_en, spr_rd_en, spr_wr_en;
   logic [13:0] lin_rd_addr, lin_wr_addr;
   logic [10:0] spr_rd_addr, spr_wr_addr;
   logic [7:0]  lin_rd_data, lin_wr_data, spr_rd_data, spr_wr_data;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   logic [7:0] lin_mem [0:16383];
   logic [7:0] spr_mem [0:2047];

   always #5 clk = ~clk;

   spare_repacker dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .dir(dir),
      .page_size(page_size), .spare_size(spare_size), .slot_stride(slot_stride),
      .busy(busy), .done(done),
      .lin_rd_en(lin_rd_en), .lin_rd_addr(lin_rd_addr), .lin_rd_data(lin_rd_data),
      .lin_wr_en(lin_wr_en), .lin_wr_addr(lin_wr_addr), .lin_wr_data(lin_wr_data),
      .spr_rd_en(spr_rd_en), .spr_rd_addr(spr_rd_addr), .spr_rd_data(spr_rd_data),
      .spr_wr_en(spr_wr_en), .spr_wr_addr(spr_wr_addr), .spr_wr_data(spr_wr_data)
   );

   always @(posedge clk) begin
      if (lin_rd_en) lin_rd_data <= lin_mem[lin_rd_addr];
      if (spr_rd_en) spr_rd_data <= spr_mem[spr_rd_addr];
      if (lin_wr_en) lin_mem[lin_wr_addr] <= lin_wr_data;
      if (spr_wr_en) spr_mem[spr_wr_addr] <= spr_wr_data;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      check(!busy && !done, req, "idle busy/done", {busy, done}, 0);
      check({lin_rd_en, spr_rd_en, lin_wr_en, spr_wr_en} == 4'b0, req, "idle enables",
            {lin_rd_en, spr_rd_en, lin_wr_en, spr_wr_en}, 0);
   endtask

   // Behavioural model: build the expected transfer list, then compare every cycle.
   task automatic run_op(input bit d, input int pg, input int sp, input int st,
                         input bit hold, input string tag);
      int src[$];
      int dst[$];
      int dat[$];
      int n, len, t_cnt, k_end;
      n = pg / 512;
      if (n < 1) n = 1;
      if (n > 8) n = 8;
      len = (sp / n) & ~1;
      for (int i = 0; i < n; i++) begin
         int cnt;
         cnt = (i < n - 1) ? len : sp - (n - 1) * len;
         for (int j = 0; j < cnt; j++) begin
            int la, sa;
            la = pg + i * len + j;
            sa = i * st + j;
            if (d) begin
               src.push_back(la); dst.push_back(sa); dat.push_back(int'(lin_mem[la]));
            end else begin
               src.push_back(sa); dst.push_back(la); dat.push_back(int'(spr_mem[sa]));
            end
         end
      end
      t_cnt = src.size();
      k_end = (t_cnt > 0) ? t_cnt + 3 : 2;
      @(negedge clk);
      dir = d; page_size = 13'(pg); spare_size = 8'(sp); slot_stride = 7'(st);
      start = 1'b1;
      for (int k = 1; k <= k_end; k++) begin
         bit rdx, wrx;
         @(negedge clk);
         if (k == 1 && !hold) start = 1'b0;
         if (k == 1 && hold) begin
            dir = ~d; page_size = 13'd4096; spare_size = 8'd200; slot_stride = 7'd3;
         end
         if (hold && k == k_end - 1) start = 1'b0;
         rdx = (k >= 2) && (k <= t_cnt + 1);
         wrx = (k >= 3) && (k <= t_cnt + 2);
         check({lin_rd_en, spr_rd_en, lin_wr_en, spr_wr_en} ==
               {rdx && d, rdx && !d, wrx && !d, wrx && d},
               {"R5 R6 ", tag}, "enables",
               {lin_rd_en, spr_rd_en, lin_wr_en, spr_wr_en},
               {rdx && d, rdx && !d, wrx && !d, wrx && d});
         if (rdx) begin
            int a;
            a = d ? int'(lin_rd_addr) : int'(spr_rd_addr);
            check(a == src[k-2], {"R3 ", tag}, "read addr", a, src[k-2]);
         end
         if (wrx) begin
            int a, v;
            a = d ? int'(spr_wr_addr) : int'(lin_wr_addr);
            v = d ? int'(spr_wr_data) : int'(lin_wr_data);
            check(a == dst[k-3], {"R3 ", tag}, "write addr", a, dst[k-3]);
            check(v == dat[k-3], {"R4 ", tag}, "write data", v, dat[k-3]);
         end
         check(done == (k == k_end), {"R7 ", tag}, "done", done, k == k_end);
         check(busy == (k < k_end), {"R8 ", tag}, "busy", busy, k < k_end);
      end
      start = 1'b0;
      @(negedge clk);
      check_idle({"R8 ", tag});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 16384; a++) lin_mem[a] = 8'(a * 37 + 5);
      for (int a = 0; a < 2048; a++)  spr_mem[a] = 8'(a * 11 + 128);
      repeat (3) @(negedge clk);
      check_idle("R11");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R11");

      run_op(1'b0, 2048, 64, 16, 1'b0, "R4");    // four even sections, stride equals length
      run_op(1'b1, 2048, 64, 64, 1'b0, "R5");    // scatter with wide stride
      run_op(1'b0, 512, 16, 16, 1'b0, "R1");     // single section
      run_op(1'b1, 2048, 60, 64, 1'b0, "R2");    // 15 rounds to 14, last takes 18
      run_op(1'b0, 1536, 50, 64, 1'b0, "R2");    // three sections, last takes 18
      run_op(1'b1, 4096, 218, 64, 1'b0, "R4");   // eight sections, last takes 36
      run_op(1'b0, 256, 20, 16, 1'b0, "R1");     // page below one sector clamps to 1
      run_op(1'b1, 8000, 32, 16, 1'b0, "R1");    // count above cap clamps to 8
      run_op(1'b0, 4096, 6, 16, 1'b0, "R2");     // zero length: one run at slot 7
      run_op(1'b0, 2048, 0, 16, 1'b0, "R10");    // nothing to move
      run_op(1'b1, 1024, 40, 64, 1'b1, "R9");    // start held, config changed mid-copy
      run_op(1'b0, 2048, 64, 16, 1'b1, "R8");    // start held during gather

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule